// File: doc/BRIEF.md
# Windowed threshold interrupt controller

This block watches measurement samples from four sensor channels (clear, green, infrared and temperature), each 14 bits wide. A configuration field chooses the channel to supervise. On every sample strobe, that channel's value is compared with a programmable window. An active-low interrupt is raised once the value has been outside the window for a programmable number of consecutive strobes.

Software reaches the block through a simple parallel register bus with single-cycle read and write strobes. The register set holds a status word, a main configuration word, an upper and a lower threshold (each split into a high and a low byte) and a persistence code. The status flags are sticky, and a read of the status word clears them. Writing the soft-reset bit returns the block to its power-up state. The shutdown bit stops sample evaluation and clears every interrupt, while the registers stay reachable.

Top module: `winthr_irq`

## Requirements
- R1: The 2-bit channel select (main configuration bits 3:2) picks the supervised channel: 00 clear, 01 green, 10 infrared, 11 temperature. The other channels never affect the interrupt.
- R2: A sample lies outside the window when it is greater than the upper threshold or less than the lower threshold. A value equal to either bound is inside the window and returns the consecutive count to zero. Samples are evaluated only on a cycle with `smp_valid` high.
- R3: The persistence code (bits 1:0 at address 0x18) needs 1, 4, 8 or 16 consecutive out-of-window samples for codes 00, 01, 10 and 11. The ambient flag sets on the sample that reaches that count.
- R4: Registers sit at these addresses: status 0x00, main configuration 0x01, upper threshold high/low 0x14/0x15, lower threshold high/low 0x16/0x17, persistence 0x18. Read data appears on `bus_rdata` one clock after the read strobe. Unused bits and unmapped addresses read as zero.
- R5: The status word shows the ambient flag at bit 0, the power-on flag at bit 2 and the shutdown control at bit 3. The reset control at bit 4 and bits 1, 5, 6 and 7 read as zero.
- R6: Once set, the ambient and power-on flags stay set until the status word is read. That read returns the values the flags held before it, and the flags clear on the same edge.
- R7: While the enable bit (main configuration bit 0) is 0, the ambient flag cannot set, and a flag already set clears on the next edge.
- R8: `irq_n` is low exactly when the ambient flag or the power-on flag is set.
- R9: Writing 1 to status bit 4 returns the configuration, threshold, persistence and shutdown registers to their power-up values and sets the power-on flag. Bit 4 reads back as zero afterwards.
- R10: With the shutdown bit set, both flags clear and samples are ignored, and all registers remain readable and writable.
- R11: Each threshold is 14 bits. Only the lower 6 bits of a high-byte write are kept, and the upper 2 bits read as zero.
- R12: After hardware reset, the power-on flag is set and `irq_n` is low. The upper threshold is 0x3FFF, and the lower threshold, configuration and persistence are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe for all four channels |
| smp_clear | input | 14 | Clear channel sample |
| smp_green | input | 14 | Green channel sample |
| smp_ir | input | 14 | Infrared channel sample |
| smp_temp | input | 14 | Temperature channel sample |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A sample strobe at one rising edge decides the flag on that same edge, so `irq_n` is already settled one edge after the strobe. The bench drives on falling edges and samples on the next falling edge. A register write takes effect on its edge. Clearing caused by a new enable or shutdown value appears one edge later, so the bench waits one extra cycle before checking those outcomes. Read data is captured on the read edge and checked at the following falling edge, after the flags have already cleared.

// File: rtl/winthr_pkg.sv
package winthr_pkg;
   // register byte width is fixed by the bus
   localparam int BYTE_W      = 8;
   // register addresses
   localparam int ADR_STAT    = 'h00;
   localparam int ADR_CFG     = 'h01;
   localparam int ADR_UP_HI   = 'h14;
   localparam int ADR_PST     = 'h18;
   localparam int NUM_THR     = 2;   // upper at index 0, lower at index 1
   // status bit positions
   localparam int ST_AMB      = 0;
   localparam int ST_PWR      = 2;
   localparam int ST_SHDN     = 3;
   localparam int ST_RST      = 4;
   // configuration bit positions
   localparam int CF_EN       = 0;
   localparam int CF_SEL_LSB  = 2;
   // persistence
   localparam int MAX_PERSIST = 16;
   localparam int CNT_W       = $clog2(MAX_PERSIST + 1);
   localparam int NUM_CH      = 4;

   typedef enum logic [1:0] {
      CH_CLEAR = 2'b00,
      CH_GREEN = 2'b01,
      CH_IR    = 2'b10,
      CH_TEMP  = 2'b11
   } chan_sel_t;

   function automatic int unsigned persist_need(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return MAX_PERSIST;
      endcase
   endfunction
endpackage

// File: rtl/winthr_regs.sv
module winthr_regs
   import winthr_pkg::*;
#(
   parameter int DW     = 14,
   parameter int ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              amb_flag,
   input  logic              pwr_flag,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              cfg_en,
   output chan_sel_t         cfg_sel,
   output logic [DW-1:0]     thr_up,
   output logic [DW-1:0]     thr_lo,
   output logic [1:0]        pst_code,
   output logic              shdn,
   output logic              soft_rst,
   output logic              stat_rd
);
   localparam int HI_W = DW - BYTE_W;

   logic [31:0]       addr_ext;
   logic [DW-1:0]     thr_v [NUM_THR];
   logic [BYTE_W-1:0] rd_mux;

   assign addr_ext = 32'(bus_addr);
   assign soft_rst = bus_wr && (addr_ext == 32'(ADR_STAT)) && bus_wdata[ST_RST];
   assign stat_rd  = bus_rd && (addr_ext == 32'(ADR_STAT));

   // status: shutdown control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    shdn <= 1'b0;
      else if (soft_rst)                             shdn <= 1'b0;
      else if (bus_wr && addr_ext == 32'(ADR_STAT))  shdn <= bus_wdata[ST_SHDN];
   end

   // main configuration and persistence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en   <= 1'b0;
         cfg_sel  <= CH_CLEAR;
         pst_code <= 2'b00;
      end else if (soft_rst) begin
         cfg_en   <= 1'b0;
         cfg_sel  <= CH_CLEAR;
         pst_code <= 2'b00;
      end else if (bus_wr) begin
         if (addr_ext == 32'(ADR_CFG)) begin
            cfg_en  <= bus_wdata[CF_EN];
            cfg_sel <= chan_sel_t'(bus_wdata[CF_SEL_LSB +: 2]);
         end
         if (addr_ext == 32'(ADR_PST))
            pst_code <= bus_wdata[1:0];
      end
   end

   // thresholds: high byte then low byte, one pair per threshold
   for (genvar gi = 0; gi < NUM_THR; gi++) begin : g_thr
      localparam logic [31:0]   A_HI  = 32'(ADR_UP_HI + 2 * gi);
      localparam logic [31:0]   A_LO  = 32'(ADR_UP_HI + 2 * gi + 1);
      localparam logic [DW-1:0] RST_V = (gi == 0) ? {DW{1'b1}} : {DW{1'b0}};
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= RST_V;
         else if (soft_rst)                   q <= RST_V;
         else if (bus_wr && addr_ext == A_HI) q[DW-1:BYTE_W] <= bus_wdata[HI_W-1:0];
         else if (bus_wr && addr_ext == A_LO) q[BYTE_W-1:0]  <= bus_wdata;
      end
      assign thr_v[gi] = q;
   end

   assign thr_up = thr_v[0];
   assign thr_lo = thr_v[1];

   // read multiplexer
   always_comb begin
      rd_mux = '0;
      if (addr_ext == 32'(ADR_STAT)) begin
         rd_mux[ST_AMB]  = amb_flag;
         rd_mux[ST_PWR]  = pwr_flag;
         rd_mux[ST_SHDN] = shdn;
      end else if (addr_ext == 32'(ADR_CFG)) begin
         rd_mux[CF_EN]               = cfg_en;
         rd_mux[CF_SEL_LSB +: 2]     = cfg_sel;
      end else if (addr_ext == 32'(ADR_PST)) begin
         rd_mux[1:0] = pst_code;
      end else begin
         for (int i = 0; i < NUM_THR; i++) begin
            if (addr_ext == 32'(ADR_UP_HI + 2 * i))
               rd_mux = BYTE_W'(thr_v[i][DW-1:BYTE_W]);
            else if (addr_ext == 32'(ADR_UP_HI + 2 * i + 1))
               rd_mux = thr_v[i][BYTE_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/winthr_persist.sv
module winthr_persist
   import winthr_pkg::*;
#(
   parameter int DW = 14
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         smp_valid,
   input  logic [NUM_CH-1:0][DW-1:0]    ch_data,
   input  chan_sel_t                    sel,
   input  logic [DW-1:0]                thr_up,
   input  logic [DW-1:0]                thr_lo,
   input  logic [1:0]                   pst_code,
   input  logic                         active,
   input  logic                         clr,
   output logic                         hit,
   output logic [CNT_W-1:0]             cnt
);
   logic [DW-1:0]    smp;
   logic             outside;
   logic [CNT_W-1:0] need;
   logic [CNT_W-1:0] cnt_inc;

   always_comb begin
      smp     = ch_data[sel];
      outside = (smp > thr_up) || (smp < thr_lo);
      need    = CNT_W'(persist_need(pst_code));
      cnt_inc = (cnt == CNT_W'(MAX_PERSIST)) ? cnt : cnt + 1'b1;
      hit     = active && smp_valid && outside && (cnt_inc >= need);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr || !active) cnt <= '0;
      else if (smp_valid)      cnt <= outside ? cnt_inc : '0;
   end
endmodule

// File: rtl/winthr_flags.sv
module winthr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic en,
   input  logic shdn,
   input  logic soft_rst,
   input  logic stat_rd,
   output logic amb_flag,
   output logic pwr_flag,
   output logic irq_n
);
   // a new event wins over a simultaneous read clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            amb_flag <= 1'b0;
      else if (soft_rst)     amb_flag <= 1'b0;
      else if (shdn || !en)  amb_flag <= 1'b0;
      else if (hit)          amb_flag <= 1'b1;
      else if (stat_rd)      amb_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pwr_flag <= 1'b1;
      else if (soft_rst) pwr_flag <= 1'b1;
      else if (shdn)     pwr_flag <= 1'b0;
      else if (stat_rd)  pwr_flag <= 1'b0;
   end

   assign irq_n = ~(amb_flag | pwr_flag);
endmodule

// File: rtl/winthr_irq.sv
module winthr_irq
   import winthr_pkg::*;
#(
   parameter int DW     = 14,
   parameter int ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DW-1:0]     smp_clear,
   input  logic [DW-1:0]     smp_green,
   input  logic [DW-1:0]     smp_ir,
   input  logic [DW-1:0]     smp_temp,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_n
);
   if (DW <= BYTE_W || DW > 2 * BYTE_W) begin : g_bad_dw
      $error("winthr_irq: DW must lie between 9 and 16");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_aw
      $error("winthr_irq: ADDR_W must reach address 0x18");
   end

   logic                       cfg_en, shdn, soft_rst, stat_rd;
   chan_sel_t                  cfg_sel;
   logic [DW-1:0]              thr_up, thr_lo;
   logic [1:0]                 pst_code;
   logic                       hit, amb_flag, pwr_flag;
   logic [CNT_W-1:0]           cnt;
   logic [NUM_CH-1:0][DW-1:0]  ch_data;

   // index equals the select code
   assign ch_data = {smp_temp, smp_ir, smp_green, smp_clear};

   winthr_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .amb_flag(amb_flag), .pwr_flag(pwr_flag),
      .bus_rdata(bus_rdata), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
      .thr_up(thr_up), .thr_lo(thr_lo), .pst_code(pst_code),
      .shdn(shdn), .soft_rst(soft_rst), .stat_rd(stat_rd)
   );

   winthr_persist #(.DW(DW)) u_persist (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .ch_data(ch_data),
      .sel(cfg_sel), .thr_up(thr_up), .thr_lo(thr_lo), .pst_code(pst_code),
      .active(cfg_en && !shdn), .clr(soft_rst), .hit(hit), .cnt(cnt)
   );

   winthr_flags u_flags (
      .clk(clk), .rst_n(rst_n), .hit(hit), .en(cfg_en), .shdn(shdn),
      .soft_rst(soft_rst), .stat_rd(stat_rd),
      .amb_flag(amb_flag), .pwr_flag(pwr_flag), .irq_n(irq_n)
   );
endmodule

// File: rtl/winthr_irq_chk.sv
module winthr_irq_chk #(
   parameter int ADDR_W = 8,
   parameter int CW     = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              irq_n,
   input logic              amb,
   input logic              pwr,
   input logic              en,
   input logic              shdn,
   input logic [CW-1:0]     cnt
);
   logic stat_acc_rd, soft_wr;
   assign stat_acc_rd = bus_rd && (bus_addr == '0);
   assign soft_wr     = bus_wr && (bus_addr == '0) && bus_wdata[4];

   // R7
   en_off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !amb);

   // R10
   shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn && !soft_wr) |=> (!amb && !pwr));

   // R6
   rd_clears_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_acc_rd && !soft_wr) |=> !pwr);

   // R6
   amb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (amb && en && !shdn && !stat_acc_rd && !soft_wr) |=> amb);

   // R5
   stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_acc_rd |=> ((bus_rdata & 8'hF2) == 8'h00));

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> ($past(smp_valid) || $past(bus_wr)));

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(16));
endmodule

bind winthr_irq winthr_irq_chk #(.ADDR_W(ADDR_W), .CW(winthr_pkg::CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .irq_n(irq_n), .amb(amb_flag), .pwr(pwr_flag),
   .en(cfg_en), .shdn(shdn), .cnt(cnt)
);

// File: tb/sim_winthr_irq.sv
module sim_winthr_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [13:0] smp_clear = '0, smp_green = '0, smp_ir = '0, smp_temp = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0, bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq_n;
   int          checks = 0, failures = 0;
   logic [7:0]  rv;

   always #10 clk = ~clk;

   winthr_irq u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_clear(smp_clear), .smp_green(smp_green), .smp_ir(smp_ir),
      .smp_temp(smp_temp), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_n(irq_n)
   );

   typedef struct packed {
      logic [13:0] grn;
      logic [13:0] clr;
      logic        exp_irq_n;
   } vec_t;

   // window 100..200 on green, persistence 4; clear channel is a decoy
   localparam vec_t VEC [12] = '{
      '{14'd150, 14'd5000, 1'b1},
      '{14'd201, 14'd150,  1'b1},
      '{14'd250, 14'd150,  1'b1},
      '{14'd200, 14'd9000, 1'b1},
      '{14'd99,  14'd150,  1'b1},
      '{14'd0,   14'd150,  1'b1},
      '{14'd300, 14'd150,  1'b1},
      '{14'd100, 14'd0,    1'b1},
      '{14'd50,  14'd150,  1'b1},
      '{14'd60,  14'd150,  1'b1},
      '{14'd70,  14'd150,  1'b1},
      '{14'd80,  14'd150,  1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic smp(input logic [13:0] c, input logic [13:0] g,
                      input logic [13:0] ir, input logic [13:0] t);
      @(negedge clk);
      smp_valid = 1'b1; smp_clear = c; smp_green = g; smp_ir = ir; smp_temp = t;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 power-up state
      chk("R12 irq_n after reset", irq_n, 1'b0);
      rd(8'h00, rv); chk("R12 status after reset", rv, 8'h04);
      chk("R6 irq_n after status read", irq_n, 1'b1);
      rd(8'h00, rv); chk("R6 status cleared by read", rv, 8'h00);
      rd(8'h01, rv); chk("R12 cfg reset", rv, 8'h00);
      rd(8'h14, rv); chk("R12 upper hi reset", rv, 8'h3F);
      rd(8'h15, rv); chk("R12 upper lo reset", rv, 8'hFF);
      rd(8'h16, rv); chk("R12 lower hi reset", rv, 8'h00);
      rd(8'h18, rv); chk("R12 persist reset", rv, 8'h00);
      rd(8'h02, rv); chk("R4 unmapped reads zero", rv, 8'h00);

      // program window 100..200, persistence 4, enable, select green
      wr(8'h14, 8'h00); wr(8'h15, 8'hC8);
      wr(8'h16, 8'h00); wr(8'h17, 8'h64);
      wr(8'h18, 8'h01); wr(8'h01, 8'h05);
      rd(8'h01, rv); chk("R4 cfg readback", rv, 8'h05);
      rd(8'h17, rv); chk("R4 lower lo readback", rv, 8'h64);

      // R1 R2 R3 table walk
      for (int i = 0; i < 12; i++) begin
         smp(VEC[i].clr, VEC[i].grn, 14'd5000, 14'd5000);
         chk($sformatf("R2 R3 R1 vector %0d irq_n", i), irq_n, VEC[i].exp_irq_n);
      end
      rd(8'h00, rv); chk("R6 read returns set ambient flag", rv, 8'h01);
      chk("R6 irq_n released after read", irq_n, 1'b1);
      smp(14'd0, 14'd150, 14'd0, 14'd0);

      // R7 enable low clears and blocks
      wr(8'h18, 8'h00);
      smp(14'd150, 14'd500, 14'd150, 14'd150);
      chk("R3 code 00 one sample", irq_n, 1'b0);
      wr(8'h01, 8'h04);
      @(negedge clk);
      chk("R7 flag cleared by disable", irq_n, 1'b1);
      smp(14'd150, 14'd500, 14'd150, 14'd150);
      chk("R7 no flag while disabled", irq_n, 1'b1);
      rd(8'h00, rv); chk("R7 status while disabled", rv, 8'h00);

      // R1 temperature and infrared selection
      wr(8'h01, 8'h0D);
      smp(14'd150, 14'd150, 14'd150, 14'd20);
      chk("R1 temperature selected", irq_n, 1'b0);
      rd(8'h00, rv); chk("R1 status after temp event", rv, 8'h01);
      smp(14'd9000, 14'd9000, 14'd9000, 14'd150);
      chk("R1 only temperature counts", irq_n, 1'b1);
      // R2 no strobe, no evaluation
      @(negedge clk); smp_temp = 14'd9000;
      repeat (5) @(negedge clk);
      chk("R2 no evaluation without strobe", irq_n, 1'b1);
      wr(8'h01, 8'h09);
      smp(14'd150, 14'd150, 14'd9000, 14'd150);
      chk("R1 infrared selected", irq_n, 1'b0);
      rd(8'h00, rv);

      // R3 persistence 16 and 8
      wr(8'h18, 8'h03); wr(8'h01, 8'h05);
      smp(14'd0, 14'd150, 14'd0, 14'd0);
      for (int i = 0; i < 15; i++) smp(14'd150, 14'd0, 14'd150, 14'd150);
      chk("R3 code 11 after 15 samples", irq_n, 1'b1);
      smp(14'd150, 14'd0, 14'd150, 14'd150);
      chk("R3 code 11 after 16 samples", irq_n, 1'b0);
      rd(8'h00, rv);
      wr(8'h18, 8'h02);
      smp(14'd0, 14'd150, 14'd0, 14'd0);
      for (int i = 0; i < 7; i++) smp(14'd150, 14'd900, 14'd150, 14'd150);
      chk("R3 code 10 after 7 samples", irq_n, 1'b1);
      smp(14'd150, 14'd900, 14'd150, 14'd150);
      chk("R3 code 10 after 8 samples", irq_n, 1'b0);

      // R10 shutdown
      wr(8'h00, 8'h08);
      @(negedge clk);
      chk("R10 shutdown clears interrupt", irq_n, 1'b1);
      for (int i = 0; i < 20; i++) smp(14'd150, 14'd900, 14'd150, 14'd150);
      chk("R10 samples ignored in shutdown", irq_n, 1'b1);
      rd(8'h00, rv); chk("R10 R5 status in shutdown", rv, 8'h08);
      wr(8'h15, 8'h77);
      rd(8'h15, rv); chk("R10 register writable in shutdown", rv, 8'h77);
      wr(8'h15, 8'hC8);
      wr(8'h00, 8'h00);
      smp(14'd150, 14'd900, 14'd150, 14'd150);
      chk("R10 count restarts after shutdown", irq_n, 1'b1);

      // R11 high byte masking
      wr(8'h14, 8'hFF);
      rd(8'h14, rv); chk("R11 upper hi masked", rv, 8'h3F);
      wr(8'h16, 8'hC5);
      rd(8'h16, rv); chk("R11 lower hi masked", rv, 8'h05);

      // R9 soft reset
      wr(8'h00, 8'h10);
      chk("R9 irq_n after soft reset", irq_n, 1'b0);
      rd(8'h00, rv); chk("R9 status after soft reset", rv, 8'h04);
      rd(8'h01, rv); chk("R9 cfg after soft reset", rv, 8'h00);
      rd(8'h14, rv); chk("R9 upper hi after soft reset", rv, 8'h3F);
      rd(8'h16, rv); chk("R9 lower hi after soft reset", rv, 8'h00);
      rd(8'h18, rv); chk("R9 persist after soft reset", rv, 8'h00);
      rd(8'h13, rv); chk("R4 address 0x13 reads zero", rv, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule